// File: doc/BRIEF.md
# Two's-Complement Posit Field Decoder

This block takes one posit word of parameterised width `N`, with an exponent field of `ES` bits, and breaks it into the fields that an arithmetic stage wants: a NaR flag, a zero flag, the sign, a signed scale (the power of two), the fraction bits, and a three-bit guard/round/sticky field that is always cleared at this stage. It is purely combinational and sits in front of an adder, multiplier or divider datapath.

Negative words are never negated. The regime run is found by folding the word onto itself with XOR, so that the run turns into leading zeros ended by a single one. A single leading-zero counter then measures it. The exponent bits of a negative word are read inverted, and the fraction bits are passed on raw. A downstream stage rebuilds a two's-complement mantissa as `{sign, ~sign, fraction}`. That mantissa lies in [-2,-1) for negative words and in [1,2) for positive ones, and together with the scale it gives the exact value of the word. For a negative word whose true fraction is zero, the scale comes out one lower and the mantissa comes out as -2, and these two offsets cancel.

Top module: `pdec_unit`

## Requirements
- R1: `is_zero_o` is 1 exactly when every input bit is 0.
- R2: `is_nar_o` is 1 exactly when the MSB is 1 and every other bit is 0. The two flags are never 1 together.
- R3: `sign_o` equals the input MSB for every input word.
- R4: `grs_o` is 3'b000 for every input word.
- R5: For a normal word with MSB 0, `scale_o` (two's complement, width clog2(N-1)+ES+1) equals 2^ES times the regime value plus the exponent. Exponent bits cut off by the regime count as 0. `frac_o` (width N-ES-3) holds the fraction bits left-aligned, zero-padded on the right.
- R6: For every normal word, M x 2^scale equals the posit value. Here M is `{sign_o, ~sign_o, frac_o}` read as a signed fixed-point number with two integer bits.
- R7: For a normal word with MSB 1 whose magnitude has an all-zero fraction, `frac_o` is 0 and `scale_o` is one less than the scale of the magnitude.
- R8: The largest positive word (0 followed by all ones) gives scale (N-2)x2^ES. The smallest positive word (all zeros then a final 1) gives scale -(N-2)x2^ES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | N | Posit word to decode |
| is_nar_o | output | 1 | Word is NaR |
| is_zero_o | output | 1 | Word is zero |
| sign_o | output | 1 | Sign bit (input MSB) |
| scale_o | output | clog2(N-1)+ES+1 | Signed power of two: regime and exponent joined |
| frac_o | output | N-ES-3 | Fraction bits, raw two's-complement bits for negative words |
| grs_o | output | 3 | Guard/round/sticky, always zero |

## Verification
Two effects can land on the same negative word. The exponent is read inverted, and an all-zero magnitude fraction lowers the scale by one. The exponent inversion can also borrow through into the regime part of the scale. Every one of the 2^N words is driven. Each result is compared with a reference decoder that first negates the word and then decodes its magnitude. For negative words, the bench judges value equality (R6) and the planned one-step scale offset (R7) together. For positive words, it also compares scale and fraction bit-exactly. Words whose regime fills the whole word, and so leaves no terminator, exponent or fraction, are reached by the same sweep.

// File: rtl/pdec_pkg.sv
// Shared helpers for the posit field decoder: width arithmetic only.
package pdec_pkg;

    // Ceiling of log2(v), at least 1; used to size counters.
    function automatic int clog2_f(input int v);
        int r;
        r = 1;
        while ((1 << r) < v) r++;
        return r;
    endfunction

endpackage

// File: rtl/pdec_lzc.sv
// Leading-zero counter.
// Assumes W >= 1. An all-zero vector returns W. The output is LW bits wide.
module pdec_lzc #(
    parameter int W  = 6,
    parameter int LW = pdec_pkg::clog2_f(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [LW-1:0] cnt_o
);
    // Scan from LSB upward so that the highest set bit sets the count last.
    always_comb begin
        cnt_o = LW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) cnt_o = LW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/pdec_regime.sv
// Regime extraction.
// XOR-folds bits [N-2:1] against [N-3:0] so that the run of equal bits
// becomes leading zeros. It counts them with one counter and returns the
// signed regime value and the run length minus one.
// Assumes N >= 4.
module pdec_regime #(
    parameter int N  = 8,
    parameter int LW = pdec_pkg::clog2_f(N - 1)
) (
    input  logic [N-1:0] word_i,
    output logic [LW:0]  regime_o,
    output logic [LW-1:0] run_o
);
    logic          pol;
    logic [N-3:0]  fold;
    logic [LW-1:0] cnt;

    // Polarity: 1 means a non-negative regime for either sign of word.
    assign pol  = word_i[N-1] ^ word_i[N-2];
    // Fold: the first change in the run becomes the first 1.
    assign fold = word_i[N-2:1] ^ word_i[N-3:0];

    pdec_lzc #(.W(N - 2), .LW(LW)) u_lzc (
        .vec_i (fold),
        .cnt_o (cnt)
    );

    // Value: count for a non-negative regime, bitwise complement (-count-1) otherwise.
    assign regime_o = pol ? {1'b0, cnt} : {1'b1, ~cnt};
    assign run_o    = cnt;
endmodule

// File: rtl/pdec_fields.sv
// Exponent and fraction split.
// Shifts the bits below the smallest regime left by (run-1), which drops
// the rest of the regime and its terminator without an adder. The top ES
// bits become the exponent, inverted for negative words. The rest is the
// fraction, passed raw.
// Assumes N-3-ES >= 1.
module pdec_fields #(
    parameter int N   = 8,
    parameter int ES  = 1,
    parameter int LW  = pdec_pkg::clog2_f(N - 1),
    parameter int FW  = N - ES - 3,
    parameter int SCW = LW + ES + 1
) (
    input  logic [N-1:0]   word_i,
    input  logic [LW:0]    regime_i,
    input  logic [LW-1:0]  run_i,
    output logic [SCW-1:0] scale_o,
    output logic [FW-1:0]  frac_o
);
    logic [N-4:0] tail;

    // Tail: exponent and fraction aligned to the top.
    assign tail = word_i[N-4:0] << run_i;

    generate
        if (ES > 0) begin : g_exp
            logic [ES-1:0] ex;
            // Exponent: read inverted when the word is negative.
            assign ex      = tail[N-4 -: ES] ^ {ES{word_i[N-1]}};
            assign scale_o = {regime_i, ex};
            assign frac_o  = tail[FW-1:0];
        end else begin : g_noexp
            assign scale_o = regime_i;
            assign frac_o  = tail;
        end
    endgenerate
endmodule

// File: rtl/pdec_unit.sv
// Top: two's-complement posit field decoder.
// Combinational. Detects the NaR and zero words and joins the regime and
// field sub-blocks. Scale and fraction carry no meaning when a flag is set.
module pdec_unit #(
    parameter int N   = 8,
    parameter int ES  = 1,
    parameter int LW  = pdec_pkg::clog2_f(N - 1),
    parameter int FW  = N - ES - 3,
    parameter int SCW = LW + ES + 1
) (
    input  logic [N-1:0]   word_i,
    output logic           is_nar_o,
    output logic           is_zero_o,
    output logic           sign_o,
    output logic [SCW-1:0] scale_o,
    output logic [FW-1:0]  frac_o,
    output logic [2:0]     grs_o
);
    logic          low_zero;
    logic [LW:0]   regime;
    logic [LW-1:0] run;

    // Special words: everything below the MSB is clear.
    assign low_zero  = ~|word_i[N-2:0];
    assign is_nar_o  = low_zero & word_i[N-1];
    assign is_zero_o = low_zero & ~word_i[N-1];
    assign sign_o    = word_i[N-1];
    // No right shift happens here, so no bits are lost.
    assign grs_o     = 3'b000;

    pdec_regime #(.N(N), .LW(LW)) u_reg (
        .word_i   (word_i),
        .regime_o (regime),
        .run_o    (run)
    );

    pdec_fields #(.N(N), .ES(ES), .LW(LW), .FW(FW), .SCW(SCW)) u_fld (
        .word_i   (word_i),
        .regime_i (regime),
        .run_i    (run),
        .scale_o  (scale_o),
        .frac_o   (frac_o)
    );
endmodule

// File: rtl/pdec_chk.sv
// Assertion checker for pdec_unit, bound to it below.
// Combinational relations only, so immediate assertions are used.
module pdec_chk #(
    parameter int N   = 8,
    parameter int ES  = 1,
    parameter int LW  = pdec_pkg::clog2_f(N - 1),
    parameter int FW  = N - ES - 3,
    parameter int SCW = LW + ES + 1
) (
    input logic [N-1:0]   word_i,
    input logic           is_nar_o,
    input logic           is_zero_o,
    input logic           sign_o,
    input logic [SCW-1:0] scale_o,
    input logic [FW-1:0]  frac_o,
    input logic [2:0]     grs_o
);
    localparam int          EXTREME = (N - 2) * (2 ** ES);
    localparam logic [N-1:0] TOPW   = {1'b0, {(N-1){1'b1}}};
    localparam logic [N-1:0] BOTW   = {{(N-1){1'b0}}, 1'b1};

    // Check every combinational relation whenever an input changes.
    always_comb begin
        p_flags_excl_r2: assert (!(is_nar_o && is_zero_o))
            else $error("NaR and zero flags both set");
        p_zero_pos_r1: assert (!is_zero_o || !sign_o)
            else $error("zero flag with sign set");
        p_nar_neg_r3: assert (!is_nar_o || sign_o)
            else $error("NaR flag without sign");
        p_grs_clear_r4: assert (grs_o == 3'b000)
            else $error("grs not clear");
        p_top_scale_r8: assert (word_i != TOPW || int'($signed(scale_o)) == EXTREME)
            else $error("largest word scale wrong");
        p_bot_scale_r8: assert (word_i != BOTW || int'($signed(scale_o)) == -EXTREME)
            else $error("smallest word scale wrong");
        p_frac_neg_r7: assert (word_i != {1'b1, BOTW[N-2:0]} || frac_o == '0)
            else $error("negative extreme fraction not zero");
    end
endmodule

bind pdec_unit pdec_chk #(.N(N), .ES(ES), .LW(LW), .FW(FW), .SCW(SCW)) u_chk (
    .word_i    (word_i),
    .is_nar_o  (is_nar_o),
    .is_zero_o (is_zero_o),
    .sign_o    (sign_o),
    .scale_o   (scale_o),
    .frac_o    (frac_o),
    .grs_o     (grs_o)
);

// File: tb/sim_pdec_unit.sv
// Scoreboard bench: the driver pushes reference results, the monitor pops and compares.
module sim_pdec_unit;
    localparam int N   = 8;
    localparam int ES  = 1;
    localparam int LW  = pdec_pkg::clog2_f(N - 1);
    localparam int FW  = N - ES - 3;
    localparam int SCW = LW + ES + 1;

    typedef struct {
        logic [N-1:0] w;
        bit           zero;
        bit           nar;
        bit           neg;
        int           scale;
        int           frac;
        real          value;
    } item_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   word = '0;
    logic           is_nar, is_zero, sign;
    logic [SCW-1:0] scale;
    logic [FW-1:0]  frac;
    logic [2:0]     grs;

    item_t q[$];
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pdec_unit #(.N(N), .ES(ES)) u0 (
        .word_i    (word),
        .is_nar_o  (is_nar),
        .is_zero_o (is_zero),
        .sign_o    (sign),
        .scale_o   (scale),
        .frac_o    (frac),
        .grs_o     (grs)
    );

    function automatic real p2(input int e);
        real r = 1.0;
        if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
        else        for (int i = 0; i < -e; i++) r = r / 2.0;
        return r;
    endfunction

    // Reference: negate when negative, then decode the magnitude by the posit definition.
    function automatic item_t refdec(input logic [N-1:0] w);
        item_t        it;
        logic [N-1:0] m;
        int           run, reg_v, pos, ex;
        bit           b;
        it.w = w;
        it.zero = (w == '0);
        it.nar  = (w == {1'b1, {(N-1){1'b0}}});
        it.neg  = w[N-1];
        m = w[N-1] ? (~w + 1'b1) : w;
        b = m[N-2];
        run = 0;
        for (int i = N - 2; i >= 0; i--) begin
            if (m[i] == b) run++;
            else break;
        end
        reg_v = b ? run - 1 : -run;
        pos = N - 2 - run - 1;
        ex = 0;
        for (int j = 0; j < ES; j++) begin
            ex = ex * 2 + ((pos - j >= 0) ? int'(m[pos - j]) : 0);
        end
        it.frac = 0;
        for (int j = 0; j < FW; j++) begin
            it.frac = it.frac * 2 + ((pos - ES - j >= 0) ? int'(m[pos - ES - j]) : 0);
        end
        it.scale = reg_v * (2 ** ES) + ex;
        it.value = (w[N-1] ? -1.0 : 1.0) * p2(it.scale) * (1.0 + real'(it.frac) / p2(FW));
        return it;
    endfunction

    task automatic chk(input bit ok, input string req, input string msg,
                       input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s word check: actual %0d expected %0d", req, msg, act, expv);
        end
    endtask

    // Driver: apply one word per cycle and queue its reference.
    task automatic drive(input logic [N-1:0] w);
        @(posedge clk);
        word = w;
        q.push_back(refdec(w));
    endtask

    // Monitor: compare at the falling edge, away from input changes.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && q.size() > 0) begin
                item_t e;
                int    sc;
                real   mant, v;
                e = q.pop_front();
                sc = int'($signed(scale));
                chk(is_zero == e.zero, "R1", "zero flag", int'(is_zero), int'(e.zero));
                chk(is_nar == e.nar, "R2", "nar flag", int'(is_nar), int'(e.nar));
                chk(sign == e.w[N-1], "R3", "sign", int'(sign), int'(e.w[N-1]));
                chk(grs == 3'b000, "R4", "grs", int'(grs), 0);
                if (!e.zero && !e.nar) begin
                    mant = e.neg ? (-2.0 + real'(frac) / p2(FW)) : (1.0 + real'(frac) / p2(FW));
                    v = mant * p2(sc);
                    chk(v == e.value, "R6", "value", int'(v * 4096.0), int'(e.value * 4096.0));
                    if (!e.neg) begin
                        chk(sc == e.scale, "R5", "scale", sc, e.scale);
                        chk(int'(frac) == e.frac, "R5", "fraction", int'(frac), e.frac);
                    end else if (e.frac == 0) begin
                        chk(sc == e.scale - 1, "R7", "scale offset", sc, e.scale - 1);
                        chk(frac == '0, "R7", "fraction", int'(frac), 0);
                    end
                    if (e.w == {1'b0, {(N-1){1'b1}}})
                        chk(sc == (N - 2) * (2 ** ES), "R8", "largest", sc, (N - 2) * (2 ** ES));
                    if (e.w == {{(N-1){1'b0}}, 1'b1})
                        chk(sc == -(N - 2) * (2 ** ES), "R8", "smallest", sc, -(N - 2) * (2 ** ES));
                end
            end
        end
    end

    // Main sequence: reset state, then every word.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(is_zero == 1'b1 && is_nar == 1'b0, "R1", "reset-state zero", int'(is_zero), 1);
        rst_n = 1'b1;
        for (int k = 0; k < (1 << N); k++) drive(N'(k));
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule